// File: doc/BRIEF.md
# Bus and Local Wake-up Detector

This block watches for wake-up requests while a bus transceiver sits in one of its low-power modes. It takes two sampled inputs: the output of the low-power bus receiver, which reports whether the bus is dominant or recessive, and the level of a local wake pin. From these it raises a one-cycle remote-wake pulse when the bus shows the required dominant/recessive pattern. It raises a one-cycle local-wake pulse when the wake pin settles at a new level. It also drives the direction of the bias current source on the wake pin.

Detection runs only while the mode controller asserts the enable input. The controller asserts it in standby, go-to-sleep and sleep. A separate block input holds detection off while the undervoltage waiting time runs. All time limits are parameters counted in clock cycles. The comparators and the current source itself are outside this block. All pins are plain control and status signals; there is no streaming interface.

Top module: `wk_wake_detector`

## Requirements
- R1: While reset is held and on the first cycle after it, both pulse outputs are 0 and `wk_bias_up` equals the parameter `BIAS_INIT_HIGH` (1 = pull-up, 0 = pull-down).
- R2: With detection active, `bus_dom` = 1 means dominant. A remote pulse needs a dominant run of at least `DOM_CYC` samples, then a recessive run of at least `REC_CYC`, then a second dominant run of at least `DOM_CYC`. It fires on the `REC_CYC`-th sample of the recessive run that follows. `remote_wake` is high in the clock cycle after the edge that samples that last recessive value, and the pattern then starts again from idle.
- R3: A dominant run that ends after fewer than `DOM_CYC` samples sends the pattern back to idle. The next dominant sample starts a new first run.
- R4: A recessive run inside the pattern that ends after fewer than `REC_CYC` samples sends the pattern back to idle. The dominant sample that ended it does not count toward a new run.
- R5: With detection active, when `wake_pin` differs from the held level for `WAKE_CYC` consecutive samples, `local_wake` pulses in the next cycle. This holds for both a high-to-low and a low-to-high change.
- R6: A change on `wake_pin` that returns to the held level before `WAKE_CYC` samples gives no pulse and leaves `wk_bias_up` unchanged.
- R7: `wk_bias_up` takes the new pin level (1 = high = pull-up, 0 = low = pull-down) in the same cycle as the `local_wake` pulse, and changes at no other time.
- R8: While `det_en` = 0, no pulse is produced. The remote pattern returns to idle and the local stability count is cleared, so no partial progress carries over. `wk_bias_up` is held.
- R9: While `det_block` = 1, the block behaves as in R8 even with `det_en` = 1.
- R10: Each pulse output is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_en | input | 1 | High in the low-power modes where detection is allowed |
| det_block | input | 1 | High during the undervoltage waiting time; suppresses detection |
| bus_dom | input | 1 | Low-power receiver output, 1 = dominant, 0 = recessive |
| wake_pin | input | 1 | Sampled level of the local wake pin |
| remote_wake | output | 1 | One-cycle pulse on a valid bus wake pattern |
| local_wake | output | 1 | One-cycle pulse on a debounced wake pin change |
| wk_bias_up | output | 1 | Wake pin bias direction, 1 = pull-up, 0 = pull-down |

## Verification
The assertions assume that `bus_dom`, `wake_pin`, `det_en` and `det_block` are already synchronous to `clk`. They also assume that `REC_CYC` and `WAKE_CYC` are at least 2 and `DOM_CYC` at least 1. The stimulus keeps within these assumptions: it changes every input only on the falling clock edge, so each rising edge samples a settled value. It also builds its runs of dominant, recessive and pin levels as whole cycle counts. Every test pattern is separated from the next by a cycle with detection disabled, so the tracker always starts from idle.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [2:0] {
    RT_IDLE,
    RT_DOM_A,
    RT_REC_A,
    RT_DOM_B,
    RT_REC_B
  } rt_state_e;
endpackage

// File: rtl/wk_run_counter.sv
module wk_run_counter #(
  parameter int W   = 4,
  parameter int MAX = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load1,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = W'(MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (load1)     cnt <= W'(1);
    else if (inc && cnt < CMAX) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/wk_remote_tracker.sv
module wk_remote_tracker
  import wk_pkg::*;
#(
  parameter int DOM_CYC = 4,
  parameter int REC_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bus_dom,
  output logic remote_pulse
);
  localparam int CMAX = (DOM_CYC > REC_CYC) ? DOM_CYC : REC_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DOM_MIN  = CW'(DOM_CYC);
  localparam logic [CW-1:0] REC_MIN  = CW'(REC_CYC);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);

  rt_state_e     state, nxt;
  logic [CW-1:0] cnt;
  logic          clr, load1, inc, fire;

  wk_run_counter #(.W(CW), .MAX(CMAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load1(load1), .inc(inc), .cnt(cnt)
  );

  always_comb begin
    nxt   = state;
    clr   = 1'b0;
    load1 = 1'b0;
    inc   = 1'b0;
    fire  = 1'b0;
    if (!active) begin
      nxt = RT_IDLE;
      clr = 1'b1;
    end else begin
      unique case (state)
        RT_IDLE: begin
          if (bus_dom) begin nxt = RT_DOM_A; load1 = 1'b1; end
          else clr = 1'b1;
        end
        RT_DOM_A, RT_DOM_B: begin
          if (bus_dom) inc = 1'b1;
          else if (cnt >= DOM_MIN) begin
            nxt   = (state == RT_DOM_A) ? RT_REC_A : RT_REC_B;
            load1 = 1'b1;
          end else begin
            nxt = RT_IDLE;
            clr = 1'b1;
          end
        end
        RT_REC_A: begin
          if (!bus_dom) inc = 1'b1;
          else if (cnt >= REC_MIN) begin
            nxt   = RT_DOM_B;
            load1 = 1'b1;
          end else begin
            nxt = RT_IDLE;
            clr = 1'b1;
          end
        end
        RT_REC_B: begin
          if (!bus_dom && cnt >= REC_LAST) begin
            fire = 1'b1;
            nxt  = RT_IDLE;
            clr  = 1'b1;
          end else if (!bus_dom) inc = 1'b1;
          else begin
            nxt = RT_IDLE;
            clr = 1'b1;
          end
        end
        default: begin
          nxt = RT_IDLE;
          clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= RT_IDLE;
      remote_pulse <= 1'b0;
    end else begin
      state        <= nxt;
      remote_pulse <= fire;
    end
  end

  a_r10_remote_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    remote_pulse |=> !remote_pulse);
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (state == RT_IDLE));
  a_r2_pulse_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    remote_pulse |-> $past(active));
  a_r2_pulse_after_second_rec: assert property (@(posedge clk) disable iff (!rst_n)
    remote_pulse |-> ($past(state) == RT_REC_B) && (state == RT_IDLE));
endmodule

// File: rtl/wk_local_debounce.sv
module wk_local_debounce #(
  parameter int WAKE_CYC       = 6,
  parameter bit BIAS_INIT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wake_pin,
  output logic local_pulse,
  output logic bias_up
);
  localparam int LW = $clog2(WAKE_CYC + 1);
  localparam logic [LW-1:0] LAST = LW'(WAKE_CYC - 1);

  logic [LW-1:0] cnt;
  logic          differ, done, clr, inc;

  assign differ = (wake_pin != bias_up);
  assign done   = active && differ && (cnt >= LAST);
  assign inc    = active && differ && !done;
  assign clr    = !active || !differ || done;

  wk_run_counter #(.W(LW), .MAX(WAKE_CYC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load1(1'b0), .inc(inc), .cnt(cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_up     <= BIAS_INIT_HIGH;
      local_pulse <= 1'b0;
    end else begin
      if (done) bias_up <= wake_pin;
      local_pulse <= done;
    end
  end

  a_r10_local_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    local_pulse |=> !local_pulse);
  a_r7_bias_only_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !local_pulse |-> $stable(bias_up));
  a_r7_bias_takes_pin: assert property (@(posedge clk) disable iff (!rst_n)
    local_pulse |-> (bias_up == $past(wake_pin)));
  a_r6_no_pulse_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pin == bias_up) |=> !local_pulse);
  a_r8_no_pulse_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !local_pulse);
endmodule

// File: rtl/wk_wake_detector.sv
module wk_wake_detector #(
  parameter int DOM_CYC        = 500,
  parameter int REC_CYC        = 500,
  parameter int WAKE_CYC       = 5000,
  parameter bit BIAS_INIT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_en,
  input  logic det_block,
  input  logic bus_dom,
  input  logic wake_pin,
  output logic remote_wake,
  output logic local_wake,
  output logic wk_bias_up
);
  logic active;
  assign active = det_en && !det_block;

  wk_remote_tracker #(.DOM_CYC(DOM_CYC), .REC_CYC(REC_CYC)) u_remote (
    .clk(clk), .rst_n(rst_n), .active(active), .bus_dom(bus_dom),
    .remote_pulse(remote_wake)
  );

  wk_local_debounce #(.WAKE_CYC(WAKE_CYC), .BIAS_INIT_HIGH(BIAS_INIT_HIGH)) u_local (
    .clk(clk), .rst_n(rst_n), .active(active), .wake_pin(wake_pin),
    .local_pulse(local_wake), .bias_up(wk_bias_up)
  );

  a_r9_block_silences: assert property (@(posedge clk) disable iff (!rst_n)
    det_block |=> !remote_wake && !local_wake);
endmodule

// File: tb/tb_wk_wake_detector.sv
module tb_wk_wake_detector;
  localparam int DOM  = 4;
  localparam int REC  = 3;
  localparam int WAKE = 6;
  localparam bit INIT = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic det_en = 1'b0, det_block = 1'b0, bus_dom = 1'b0, wake_pin = INIT;
  logic remote_wake, local_wake, wk_bias_up;

  int tests = 0, fails = 0;
  int n_rw = 0, n_lw = 0, max_w_rw = 0, max_w_lw = 0, w_rw = 0, w_lw = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wk_wake_detector #(.DOM_CYC(DOM), .REC_CYC(REC), .WAKE_CYC(WAKE), .BIAS_INIT_HIGH(INIT)) dut (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .det_block(det_block),
    .bus_dom(bus_dom), .wake_pin(wake_pin),
    .remote_wake(remote_wake), .local_wake(local_wake), .wk_bias_up(wk_bias_up)
  );

  // Behavioural reference: phase number and run length of the bus pattern,
  // plus a stability count for the wake pin.
  int  ph = 0, rl = 0, lc = 0;
  bit  e_rw = 0, e_lw = 0, e_bias = INIT;

  always @(posedge clk) begin
    e_rw = 0; e_lw = 0;
    if (!rst_n) begin ph = 0; rl = 0; lc = 0; e_bias = INIT; end
    else if (!(det_en && !det_block)) begin ph = 0; rl = 0; lc = 0; end
    else begin
      if (ph == 0) begin
        if (bus_dom) begin ph = 1; rl = 1; end
      end else if (ph == 1 || ph == 3) begin
        if (bus_dom) rl++;
        else if (rl >= DOM) begin ph++; rl = 1; end
        else begin ph = 0; rl = 0; end
      end else begin
        if (!bus_dom) begin
          rl++;
          if (ph == 4 && rl == REC) begin e_rw = 1; ph = 0; rl = 0; end
        end else if (ph == 2 && rl >= REC) begin ph = 3; rl = 1; end
        else begin ph = 0; rl = 0; end
      end
      if (wake_pin != e_bias) begin
        lc++;
        if (lc == WAKE) begin e_bias = wake_pin; e_lw = 1; lc = 0; end
      end else lc = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 remote_wake per-cycle", remote_wake, e_rw);
      check("R5 local_wake per-cycle", local_wake, e_lw);
      check("R7 wk_bias_up per-cycle", wk_bias_up, e_bias);
      if (remote_wake) begin n_rw++; w_rw++; if (w_rw > max_w_rw) max_w_rw = w_rw; end else w_rw = 0;
      if (local_wake)  begin n_lw++; w_lw++; if (w_lw > max_w_lw) max_w_lw = w_lw; end else w_lw = 0;
    end
  end

  task automatic seg(input bit b, input int n);
    bus_dom = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(input bit v, input int n);
    wake_pin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_pattern();
    det_en = 1'b0; bus_dom = 1'b0;
    repeat (2) @(negedge clk);
    det_en = 1'b1;
  endtask

  initial begin
    int b0;
    repeat (3) @(negedge clk);
    check("R1 reset remote_wake", remote_wake, 0);
    check("R1 reset local_wake", local_wake, 0);
    check("R1 reset bias", wk_bias_up, INIT);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset bias", wk_bias_up, INIT);
    det_en = 1'b1;
    @(negedge clk);

    // R2: exact minimum lengths
    b0 = n_rw;
    seg(1, DOM); seg(0, REC); seg(1, DOM); seg(0, REC + 4);
    check("R2 exact pattern gives one pulse", n_rw - b0, 1);
    clear_pattern();
    b0 = n_rw;
    seg(1, DOM + 3); seg(0, REC + 5); seg(1, DOM + 1); seg(0, REC + 2);
    check("R2 long runs give one pulse", n_rw - b0, 1);
    clear_pattern();

    // R3: short first dominant
    b0 = n_rw;
    seg(1, DOM - 1); seg(0, REC); seg(1, DOM); seg(0, REC + 1);
    check("R3 short dominant restarts", n_rw - b0, 0);
    clear_pattern();
    // R3: short second dominant
    b0 = n_rw;
    seg(1, DOM); seg(0, REC); seg(1, DOM - 1); seg(0, REC + 2);
    check("R3 short second dominant", n_rw - b0, 0);
    clear_pattern();

    // R4: short recessive inside pattern
    b0 = n_rw;
    seg(1, DOM + 1); seg(0, REC - 1); seg(1, DOM + 1); seg(0, REC + 1);
    check("R4 short recessive restarts", n_rw - b0, 0);
    clear_pattern();
    b0 = n_rw;
    seg(1, DOM); seg(0, REC - 1); seg(1, DOM + 1); seg(0, REC); seg(1, DOM); seg(0, REC + 1);
    check("R4 interrupting dominant not counted", n_rw - b0, 1);
    clear_pattern();

    // R8: disabled and mid-pattern disable
    b0 = n_rw;
    det_en = 1'b0;
    seg(1, DOM); seg(0, REC); seg(1, DOM); seg(0, REC + 2);
    check("R8 disabled remote", n_rw - b0, 0);
    det_en = 1'b1;
    seg(1, DOM); seg(0, REC);
    det_en = 1'b0; @(negedge clk); det_en = 1'b1;
    seg(1, DOM); seg(0, REC + 2);
    check("R8 partial pattern dropped", n_rw - b0, 0);
    clear_pattern();

    // R9: blocked
    b0 = n_rw;
    det_block = 1'b1;
    seg(1, DOM); seg(0, REC); seg(1, DOM); seg(0, REC + 2);
    check("R9 blocked remote", n_rw - b0, 0);
    det_block = 1'b0;
    clear_pattern();

    // R5/R7: local high-to-low then low-to-high
    b0 = n_lw;
    pin(0, WAKE + 3);
    check("R5 falling change pulse", n_lw - b0, 1);
    check("R7 bias pull-down", wk_bias_up, 0);
    pin(1, WAKE + 3);
    check("R5 rising change pulse", n_lw - b0, 2);
    check("R7 bias pull-up", wk_bias_up, 1);

    // R6: glitch shorter than WAKE
    b0 = n_lw;
    pin(0, WAKE - 1); pin(1, WAKE + 2);
    check("R6 glitch no pulse", n_lw - b0, 0);
    check("R6 bias unchanged", wk_bias_up, 1);

    // R9 / R8 on local
    b0 = n_lw;
    det_block = 1'b1;
    pin(0, WAKE + 2);
    check("R9 blocked local", n_lw - b0, 0);
    check("R9 bias held", wk_bias_up, 1);
    det_block = 1'b0;
    repeat (WAKE + 2) @(negedge clk);
    check("R9 resumes after unblock", n_lw - b0, 1);
    pin(1, WAKE - 2);
    det_en = 1'b0; @(negedge clk); det_en = 1'b1;
    repeat (WAKE - 2) @(negedge clk);
    check("R8 local count cleared", n_lw - b0, 1);
    check("R8 bias held", wk_bias_up, 0);
    repeat (4) @(negedge clk);
    check("R8 pulse after full restart", n_lw - b0, 2);

    // R10
    check("R10 remote pulse width", max_w_rw, 1);
    check("R10 local pulse width", max_w_lw, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule